// File: doc/BRIEF.md
# DDR2 Bank Command Timing Tracker

This block tracks, for an eight-bank DDR2-style memory controller, every timing rule that decides whether a command may go to the memory in the current cycle. Each cycle it shows, for every bank, whether an ACTIVATE, a READ or WRITE, or a single-bank PRECHARGE would be legal. It also shows whether a PRECHARGE-ALL would be legal. The command scheduler reads these outputs, picks a command and presents it on the command inputs with a valid strobe. The tracker then updates its bank and window state from the command it accepts.

Each bank runs a four-state machine. The states are IDLE (closed), OPEN (row active), AP_PENDING (a read or write with auto-precharge has been taken and the internal precharge is held back) and PRECHARGING (recovery after a precharge). The transitions are: IDLE to OPEN on ACTIVATE. OPEN to AP_PENDING on READ or WRITE with auto-precharge. OPEN to PRECHARGING on PRECHARGE. AP_PENDING to PRECHARGING when its internal precharge time arrives. PRECHARGING to OPEN on ACTIVATE once recovery is done. PRECHARGING to IDLE when recovery ends with no ACTIVATE. Any state goes to PRECHARGING on PRECHARGE-ALL. Each bank has one down-counter. It holds the cycles left before precharge while the bank is OPEN or AP_PENDING, and the cycles left of recovery while it is PRECHARGING. A shared unit enforces the activate-to-activate spacing and a rolling window of four ACTIVATEs. A command presented while its permission is low is dropped, and a sticky flag records it.

All timings are counted in clocks. The defaults are tRAS 8, tRP 3, tRRD 2, tFAW 10, tRTP 3, tWR 4, AL 0, CL 3, BL 4. With these, read-to-precharge is 3, write-to-precharge is 8 and precharge-all recovery is 4.

Top module: `ddr2_cmd_timer`

## Requirements
- R1: After reset every bank is closed. Every bit of `act_ok` is 1. `rd_ok`, `wr_ok` and `pre_ok` are all 0. `prea_ok` is 1 and `violation` is 0.
- R2: Command codes on `cmd_kind` are 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE and 4 PRECHARGE-ALL; codes 5 to 7 are never allowed. READ and WRITE are allowed only to an OPEN bank. ACTIVATE is allowed only to a bank that is closed and has finished its precharge recovery.
- R3: Two ACTIVATEs to any banks are at least T_RRD cycles apart.
- R4: An ACTIVATE at cycle t is allowed only if the fourth most recent ACTIVATE was at cycle t−T_FAW or earlier.
- R5: PRECHARGE to a bank is allowed no earlier than T_RAS cycles after its ACTIVATE.
- R6: PRECHARGE is allowed no earlier than max(T_RTP, AL+BL/2) cycles after a READ to the same bank. The R5 rule still applies.
- R7: A READ with auto-precharge is accepted even before T_RAS has elapsed. The internal precharge occurs at the later of ACTIVATE+T_RAS and READ+max(T_RTP, AL+BL/2). The bank can be activated again T_RP cycles after that. No READ, WRITE or PRECHARGE is allowed to the bank in between.
- R8: For a WRITE with auto-precharge, the internal precharge occurs no earlier than (AL+CL−1)+BL/2+T_WR cycles after the WRITE, and no earlier than ACTIVATE+T_RAS. The bank can be activated again T_RP cycles later.
- R9: After a single-bank PRECHARGE at cycle t, ACTIVATE to that bank is blocked until cycle t+T_RP.
- R10: After PRECHARGE-ALL at cycle t, ACTIVATE to every bank, including banks that were already closed, is blocked until cycle t+T_RP+1.
- R11: PRECHARGE-ALL is allowed only when no bank has a pending auto-precharge and every OPEN bank meets its PRECHARGE rule.
- R12: A command with `cmd_valid` high whose permission is low changes no state. It sets `violation`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 3 | Command code (see R2) |
| cmd_bank | input | 3 | Target bank |
| cmd_ap | input | 1 | Auto-precharge with READ or WRITE |
| act_ok | output | 8 | Per bank: ACTIVATE allowed now |
| rd_ok | output | 8 | Per bank: READ allowed now |
| wr_ok | output | 8 | Per bank: WRITE allowed now |
| pre_ok | output | 8 | Per bank: PRECHARGE allowed now |
| prea_ok | output | 1 | PRECHARGE-ALL allowed now |
| violation | output | 1 | Sticky: a disallowed command was issued |

## Verification
The hardest case to reach is a bank in AP_PENDING whose internal precharge is set by write recovery rather than by the minimum active time. A second hard case is an ACTIVATE blocked only by the four-activate window while the pairwise spacing is already met. To reach the first, the stimulus activates a bank and writes with auto-precharge one cycle later, so the two deadlines differ by one clock. It then samples the cycle between them. To reach the second, the stimulus issues four ACTIVATEs exactly T_RRD apart and then probes a fifth bank on each cycle until the window opens.

// File: rtl/ddr2_trk_pkg.sv
package ddr2_trk_pkg;

    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_PRE  = 3'd3,
        OP_PREA = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_APWAIT  = 2'd2,
        BK_PRECH   = 2'd3
    } bank_st_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_bank_tracker.sv
module ddr2_bank_tracker
    import ddr2_trk_pkg::*;
#(
    parameter int T_RAS  = 8,
    parameter int T_RP   = 3,
    parameter int RD2PRE = 3,
    parameter int WR2PRE = 8,
    parameter int CW     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_rd,
    input  logic do_wr,
    input  logic do_pre,
    input  logic do_prea,
    input  logic ap,
    output logic act_ready,
    output logic rw_ready,
    output logic pre_ready,
    output logic prea_clear
);

    localparam logic [CW-1:0] L_RAS  = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_RP   = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_RPA  = CW'(T_RP);
    localparam logic [CW-1:0] L_RD   = CW'(RD2PRE - 1);
    localparam logic [CW-1:0] L_WR   = CW'(WR2PRE - 1);

    bank_st_e        state_q, state_d;
    logic [CW-1:0]   wait_q, wait_d;
    logic [CW-1:0]   wait_dec;
    logic [CW-1:0]   span;

    assign wait_dec = (wait_q == '0) ? '0 : wait_q - 1'b1;
    assign span     = do_wr ? L_WR : L_RD;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        wait_d  = wait_dec;
        if (do_prea) begin
            state_d = BK_PRECH;
            wait_d  = L_RPA;
        end else begin
            unique case (state_q)
                BK_IDLE: begin
                    if (do_act) begin
                        state_d = BK_OPEN;
                        wait_d  = L_RAS;
                    end
                end
                BK_OPEN: begin
                    if (do_pre) begin
                        state_d = BK_PRECH;
                        wait_d  = L_RP;
                    end else if (do_rd || do_wr) begin
                        wait_d = (wait_dec > span) ? wait_dec : span;
                        if (ap) state_d = BK_APWAIT;
                    end
                end
                BK_APWAIT: begin
                    if (wait_q == '0) begin
                        state_d = BK_PRECH;
                        wait_d  = L_RP;
                    end
                end
                BK_PRECH: begin
                    if (do_act) begin
                        state_d = BK_OPEN;
                        wait_d  = L_RAS;
                    end else if (wait_q == '0) begin
                        state_d = BK_IDLE;
                    end
                end
                default: state_d = BK_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        act_ready  = (state_q == BK_IDLE) || ((state_q == BK_PRECH) && (wait_q == '0));
        rw_ready   = (state_q == BK_OPEN);
        pre_ready  = (state_q == BK_OPEN) && (wait_q == '0);
        prea_clear = (state_q == BK_IDLE) || (state_q == BK_PRECH) ||
                     ((state_q == BK_OPEN) && (wait_q == '0));
    end

    // R2: an accepted ACTIVATE opens the bank and closes its activate permission
    a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (do_act && !do_prea && act_ready) |=> (rw_ready && !act_ready));

    // R7: a pending auto-precharge holds until its counter is exhausted
    a_r7_ap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_APWAIT && wait_q != '0 && !do_prea) |=> (state_q == BK_APWAIT));

    // R10: precharge-all blocks activation on the next cycle for every bank
    a_r10_prea_block: assert property (@(posedge clk) disable iff (!rst_n)
        do_prea |=> (!act_ready && !rw_ready));

endmodule

// File: rtl/ddr2_act_window.sv
module ddr2_act_window #(
    parameter int T_RRD = 2,
    parameter int T_FAW = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_fire,
    output logic act_gate
);

    localparam int DEPTH = 4;
    localparam int RW    = $clog2(T_RRD + 1);
    localparam int FW    = $clog2(T_FAW + 1);
    localparam logic [RW-1:0] L_RRD = RW'(T_RRD - 1);
    localparam logic [FW-1:0] L_FAW = FW'(T_FAW);

    logic [RW-1:0] rrd_q;
    logic [FW-1:0] age_q [DEPTH];
    logic [FW-1:0] age_inc [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_inc
            assign age_inc[i] = (age_q[i] >= L_FAW) ? L_FAW : age_q[i] + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_q <= '0;
            for (int i = 0; i < DEPTH; i++) age_q[i] <= L_FAW;
        end else begin
            if (act_fire)          rrd_q <= L_RRD;
            else if (rrd_q != '0)  rrd_q <= rrd_q - 1'b1;
            if (act_fire) begin
                age_q[0] <= FW'(1);
                for (int i = 1; i < DEPTH; i++) age_q[i] <= age_inc[i-1];
            end else begin
                for (int i = 0; i < DEPTH; i++) age_q[i] <= age_inc[i];
            end
        end
    end

    assign act_gate = (rrd_q == '0) && (age_q[DEPTH-1] >= L_FAW);

    // R3: an activate reloads the pairwise spacing counter
    a_r3_rrd_reload: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |=> (rrd_q == L_RRD));

    // R4: an activate is recorded as the newest window entry
    a_r4_window_push: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |=> (age_q[0] == FW'(1)));

endmodule

// File: rtl/ddr2_cmd_timer.sv
module ddr2_cmd_timer
    import ddr2_trk_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int T_RAS = 8,
    parameter int T_RP  = 3,
    parameter int T_RRD = 2,
    parameter int T_FAW = 10,
    parameter int T_RTP = 3,
    parameter int T_WR  = 4,
    parameter int AL    = 0,
    parameter int CL    = 3,
    parameter int BL    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_kind,
    input  logic [2:0]           cmd_bank,
    input  logic                 cmd_ap,
    output logic [NUM_BANKS-1:0] act_ok,
    output logic [NUM_BANKS-1:0] rd_ok,
    output logic [NUM_BANKS-1:0] wr_ok,
    output logic [NUM_BANKS-1:0] pre_ok,
    output logic                 prea_ok,
    output logic                 violation
);

    localparam int WL     = AL + CL - 1;
    localparam int RD2PRE = imax(T_RTP, AL + BL / 2);
    localparam int WR2PRE = WL + BL / 2 + T_WR;
    localparam int MAXV   = imax(imax(T_RAS, T_RP + 1), imax(RD2PRE, WR2PRE));
    localparam int CW     = $clog2(MAXV + 1);

    logic [NUM_BANKS-1:0] bk_act, bk_rw, bk_pre, bk_prea;
    logic                 act_gate;
    logic                 allowed, accept;
    logic                 viol_q;

    assign act_ok  = bk_act & {NUM_BANKS{act_gate}};
    assign rd_ok   = bk_rw;
    assign wr_ok   = bk_rw;
    assign pre_ok  = bk_pre;
    assign prea_ok = &bk_prea;

    always_comb begin
        unique case (cmd_kind)
            OP_ACT:  allowed = act_ok[cmd_bank];
            OP_RD:   allowed = rd_ok[cmd_bank];
            OP_WR:   allowed = wr_ok[cmd_bank];
            OP_PRE:  allowed = pre_ok[cmd_bank];
            OP_PREA: allowed = prea_ok;
            default: allowed = 1'b0;
        endcase
    end

    assign accept = cmd_valid && allowed;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic hit;
            assign hit = accept && (cmd_bank == 3'(b));
            ddr2_bank_tracker #(
                .T_RAS(T_RAS), .T_RP(T_RP), .RD2PRE(RD2PRE), .WR2PRE(WR2PRE), .CW(CW)
            ) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .do_act    (hit && cmd_kind == OP_ACT),
                .do_rd     (hit && cmd_kind == OP_RD),
                .do_wr     (hit && cmd_kind == OP_WR),
                .do_pre    (hit && cmd_kind == OP_PRE),
                .do_prea   (accept && cmd_kind == OP_PREA),
                .ap        (cmd_ap),
                .act_ready (bk_act[b]),
                .rw_ready  (bk_rw[b]),
                .pre_ready (bk_pre[b]),
                .prea_clear(bk_prea[b])
            );
        end
    endgenerate

    ddr2_act_window #(.T_RRD(T_RRD), .T_FAW(T_FAW)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_fire(accept && cmd_kind == OP_ACT),
        .act_gate(act_gate)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                     viol_q <= 1'b0;
        else if (cmd_valid && !allowed) viol_q <= 1'b1;
    end
    assign violation = viol_q;

    // R12: the violation flag never clears without reset
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);

    // R12: a disallowed command raises the flag on the next cycle
    a_r12_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !allowed) |=> violation);

endmodule

// File: tb/sim_ddr2_cmd_timer.sv
module sim_ddr2_cmd_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NSTEP = 53;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [2:0] cmd_kind;
    logic [2:0] cmd_bank;
    logic       cmd_ap;
    logic [7:0] act_ok, rd_ok, wr_ok, pre_ok;
    logic       prea_ok, violation;

    int checks = 0;
    int errors = 0;

    ddr2_cmd_timer u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .act_ok(act_ok), .rd_ok(rd_ok),
        .wr_ok(wr_ok), .pre_ok(pre_ok), .prea_ok(prea_ok), .violation(violation)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // entry: {check, valid, kind[3], bank[3], ap, watch[3], exp{act,rw,pre,prea}, req[4]}
    function automatic logic [19:0] ev(input bit c, input bit v, input int k, input int b,
                                       input bit a, input int w, input logic [3:0] e,
                                       input int r);
        return {c, v, 3'(k), 3'(b), a, 3'(w), e, 4'(r)};
    endfunction

    localparam logic [19:0] NOP = 20'd0;

    localparam logic [19:0] VEC [NSTEP] = '{
        ev(1,1,0,0,0,0,4'b1001,2),  // c0  ACT b0, R2
        ev(1,1,1,0,0,0,4'b0100,2),  // c1  RD b0 open, R2
        ev(1,1,0,1,0,1,4'b1000,3),  // c2  ACT b1 after spacing, R3
        ev(1,0,0,0,0,2,4'b0000,3),  // c3  spacing blocks, R3
        ev(1,1,0,2,0,2,4'b1000,3),  // c4  ACT b2, R3
        NOP,                        // c5
        ev(1,1,0,3,0,3,4'b1000,3),  // c6  ACT b3, R3
        ev(1,0,0,0,0,4,4'b0000,3),  // c7  spacing blocks, R3
        ev(1,1,3,0,0,0,4'b0110,5),  // c8  PRE b0 at tRAS, R5
        ev(1,0,0,0,0,4,4'b0000,4),  // c9  window blocks, R4
        ev(1,1,0,4,0,4,4'b1000,4),  // c10 window opens, R4
        ev(1,0,0,0,0,0,4'b0000,9),  // c11 b0 recovered but gated, R9
        ev(1,1,0,0,0,0,4'b1000,9),  // c12 ACT b0, R9
        ev(1,1,1,0,1,0,4'b0100,7),  // c13 RD+AP early, R7
        ev(1,0,0,0,0,0,4'b0000,7),  // c14 AP pending, R7
        NOP, NOP, NOP, NOP, NOP,    // c15..c19
        ev(1,0,0,0,0,0,4'b0000,11), // c20 AP pending blocks PREA, R11
        ev(1,0,0,0,0,0,4'b0001,7),  // c21 precharging, R7
        ev(1,0,0,0,0,0,4'b0001,7),  // c22 R7
        ev(1,1,0,0,0,0,4'b1001,7),  // c23 ACT b0 again, R7
        ev(1,1,2,0,1,0,4'b0100,8),  // c24 WR+AP, R8
        NOP, NOP, NOP, NOP, NOP, NOP, // c25..c30
        ev(1,0,0,0,0,0,4'b0000,8),  // c31 past tRAS, write recovery holds, R8
        ev(1,0,0,0,0,0,4'b0000,8),  // c32 R8
        NOP,                        // c33
        ev(1,0,0,0,0,0,4'b0001,8),  // c34 R8
        ev(1,0,0,0,0,0,4'b1001,8),  // c35 R8
        ev(1,1,4,0,0,5,4'b1001,11), // c36 PREA, R11
        ev(1,0,0,0,0,0,4'b0001,10), // c37 R10
        NOP,                        // c38
        ev(1,0,0,0,0,5,4'b0001,10), // c39 idle bank still blocked, R10
        ev(1,1,0,5,0,5,4'b1001,10), // c40 ACT b5, R10
        NOP, NOP, NOP, NOP, NOP, NOP, NOP, // c41..c47
        ev(1,1,1,5,0,5,4'b0111,5),  // c48 RD b5 at tRAS, R5
        ev(1,0,0,0,0,5,4'b0100,6),  // c49 read-to-pre, R6
        ev(1,0,0,0,0,5,4'b0100,6),  // c50 R6
        ev(1,1,3,5,0,5,4'b0111,6),  // c51 PRE b5, R6
        ev(1,0,0,0,0,5,4'b0001,9)   // c52 R9
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check_reset_state(input string tag);
        check("R1", {tag, " act_ok"}, 32'(act_ok), 32'hFF);
        check("R1", {tag, " rd/wr/pre"}, 32'({rd_ok, wr_ok, pre_ok}), 32'h0);
        check("R1", {tag, " prea/viol"}, 32'({prea_ok, violation}), 32'b10);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [19:0] v;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = '0; cmd_bank = '0; cmd_ap = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state("reset R1");
        rst_n = 1'b1;

        for (int i = 0; i < NSTEP; i++) begin
            v = VEC[i];
            if (v[19])
                check($sformatf("R%0d", v[3:0]), $sformatf("step %0d bank %0d", i, v[10:8]),
                      32'({act_ok[v[10:8]], rd_ok[v[10:8]], pre_ok[v[10:8]], prea_ok}),
                      32'(v[7:4]));
            if (v[19] && v[18] && (v[17:15] == 3'd1 || v[17:15] == 3'd2))
                check("R2", $sformatf("step %0d wr_ok matches rd_ok", i),
                      32'(wr_ok[v[14:12]]), 32'(rd_ok[v[14:12]]));
            cmd_valid = v[18]; cmd_kind = v[17:15]; cmd_bank = v[14:12]; cmd_ap = v[11];
            @(negedge clk);
        end
        cmd_valid = 1'b0; cmd_ap = 1'b0;
        repeat (4) @(negedge clk);

        // R12: all table commands were legal
        check("R12", "no violation after legal traffic", 32'(violation), 32'd0);
        check("R12", "bank6 closed before illegal read", 32'({act_ok[6], rd_ok[6]}), 32'b10);
        cmd_valid = 1'b1; cmd_kind = 3'd1; cmd_bank = 3'd6;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R12", "violation raised", 32'(violation), 32'd1);
        check("R12", "illegal read ignored", 32'({act_ok[6], rd_ok[6]}), 32'b10);
        // R2: code 5 is never allowed
        cmd_valid = 1'b1; cmd_kind = 3'd5; cmd_bank = 3'd0;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = 3'd0;
        repeat (2) @(negedge clk);
        check("R12", "violation sticky", 32'(violation), 32'd1);
        check("R2", "undefined code leaves banks closed", 32'(act_ok), 32'hFF);

        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("re-reset R1");
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule